// File: doc/BRIEF.md
# Parallel ADC Readout Sequencer

This block is the host-side controller for a 16-bit successive-approximation converter that has a parallel output bus. A request on `trig` starts a conversion. The block pulses the active-low start strobe and holds the chip select low. It then waits for the converter's busy line to rise and fall, and reads the result. In wide mode it reads the whole result from the 16-bit bus in one read. In narrow mode it reads the result as two bytes over bus bits [7:0], and the byte-select line chooses which byte is on the bus.

Every pulse width and every gap is a parameter counted in system clock cycles. The defaults assume a 100 MHz clock. The block also keeps a quiet time after the last read before it starts the next conversion. This quiet time covers the converter's acquisition time and the read-to-start hold. If the busy line never completes its rise and fall, a timeout drops the conversion and reports an error. The result is passed through unchanged as a 16-bit two's-complement word.

Top module: `adc_par_seq`

## Requirements
- R1: After reset, `adc_go_n`, `adc_sel_n` and `adc_read_n` are high, and `adc_half`, `res_valid` and `res_err` are low.
- R2: When `trig` is accepted, `adc_go_n` is driven low for exactly CONV_LO_CYC cycles, with `adc_sel_n` low.
- R3: No read is started until `adc_active` has gone high and then low again, and `adc_read_n` is never low while `adc_active` is high.
- R4: Each read holds `adc_read_n` low for exactly RD_LO_CYC cycles, with `adc_sel_n` low. The bus is sampled in the last low cycle.
- R5: In wide mode (`narrow`=0 when `trig` is accepted), one read is done and `res_data` equals the whole 16-bit bus.
- R6: In narrow mode (`narrow`=1), two reads are done. The first read has `adc_half`=0 and returns the upper byte on bus bits [7:0]. The second read has `adc_half`=1 and returns the lower byte. The result is {first, second}. Between the two reads, `adc_read_n` stays high for at least RD_HI_CYC cycles, and `adc_half` changes only while `adc_read_n` is high.
- R7: `res_valid` is a single-cycle pulse, and `res_data` carries the result in that cycle.
- R8: At least HOLD = max(GUARD_CYC, ACQ_CYC, CONV_HI_CYC) cycles pass between the rise of `adc_read_n` at the end of a conversion's last read and the next fall of `adc_go_n`. A `trig` held high through this window is serviced when the window ends.
- R9: If `adc_active` has not completed its rise and fall within TIMEOUT_CYC cycles of the fall of `adc_go_n`, `res_err` pulses exactly TIMEOUT_CYC cycles after that fall. No `res_valid` is produced for that conversion, and `adc_sel_n` and `adc_read_n` return high.
- R10: `trig` has no effect while a conversion or read is in progress, so no extra fall of `adc_go_n` occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| trig | input | 1 | Conversion request, level sensitive in idle |
| narrow | input | 1 | 1 selects two byte reads, 0 selects one 16-bit read |
| adc_active | input | 1 | Converter busy indication |
| adc_data | input | 16 | Sampled converter data bus |
| adc_go_n | output | 1 | Active-low conversion start strobe |
| adc_sel_n | output | 1 | Active-low converter select |
| adc_read_n | output | 1 | Active-low read strobe |
| adc_half | output | 1 | Byte select: 0 for upper byte, 1 for lower byte |
| res_valid | output | 1 | One-cycle result strobe |
| res_data | output | 16 | Two's-complement result |
| res_err | output | 1 | One-cycle timeout error strobe |

## Verification
The busy-overlap assertion relies on the converter keeping `adc_active` low from the end of a conversion until the next start strobe. The bench's converter model does this: it raises busy only after a start strobe and drops it only once. The timeout scenarios break only the busy rise and fall, and never the quiet period. The bench's model drives valid data only while the read strobe is low and puts a junk pattern on the bus otherwise, so a sample taken at the wrong time gives a wrong result.

// File: rtl/adc_par_seq.sv
module adc_par_seq #(
  parameter int DATA_W       = 16,
  parameter int CONV_LO_CYC  = 2,
  parameter int CONV_HI_CYC  = 2,
  parameter int RD_LO_CYC    = 5,
  parameter int RD_HI_CYC    = 2,
  parameter int HALF_GAP_CYC = 5,
  parameter int GUARD_CYC    = 5,
  parameter int ACQ_CYC      = 15,
  parameter int TIMEOUT_CYC  = 100
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              trig,
  input  logic              narrow,
  input  logic              adc_active,
  input  logic [DATA_W-1:0] adc_data,
  output logic              adc_go_n,
  output logic              adc_sel_n,
  output logic              adc_read_n,
  output logic              adc_half,
  output logic              res_valid,
  output logic [DATA_W-1:0] res_data,
  output logic              res_err
);
  localparam int HB      = DATA_W / 2;
  localparam int HOLD_A  = (GUARD_CYC > ACQ_CYC) ? GUARD_CYC : ACQ_CYC;
  localparam int HOLD    = (HOLD_A > CONV_HI_CYC) ? HOLD_A : CONV_HI_CYC;
  localparam int GAP_CYC = (HALF_GAP_CYC - RD_LO_CYC > RD_HI_CYC) ? HALF_GAP_CYC - RD_LO_CYC : RD_HI_CYC;
  localparam int CNT_W   = $clog2(TIMEOUT_CYC + HOLD + GAP_CYC + RD_LO_CYC + CONV_LO_CYC + 2);
  localparam logic [CNT_W-1:0] K_CONV = CNT_W'(CONV_LO_CYC - 1);
  localparam logic [CNT_W-1:0] K_RD   = CNT_W'(RD_LO_CYC - 1);
  localparam logic [CNT_W-1:0] K_GAP  = CNT_W'(GAP_CYC - 1);
  localparam logic [CNT_W-1:0] K_HOLD = CNT_W'(HOLD);
  localparam logic [CNT_W-1:0] K_TMO  = CNT_W'(TIMEOUT_CYC - 1);

  typedef enum logic [4:0] {
    S_IDLE = 5'b00001, S_CONV = 5'b00010, S_WAIT = 5'b00100,
    S_READ = 5'b01000, S_GAP  = 5'b10000
  } st_t;

  st_t              st;
  logic [CNT_W-1:0] cnt, hold, tmo;
  logic             mode_q, second, seen_hi;
  logic [HB-1:0]    upper;

  assign adc_go_n   = (st != S_CONV);
  assign adc_read_n = (st != S_READ);
  assign adc_sel_n  = (st == S_IDLE);
  assign adc_half   = second;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; cnt <= '0; hold <= '0; tmo <= '0;
      mode_q <= 1'b0; second <= 1'b0; seen_hi <= 1'b0; upper <= '0;
      res_valid <= 1'b0; res_err <= 1'b0; res_data <= '0;
    end else begin
      res_valid <= 1'b0;
      res_err   <= 1'b0;
      if (st == S_CONV || st == S_WAIT) tmo <= tmo + 1'b1;
      unique case (st)
        S_IDLE: begin
          if (hold != '0) hold <= hold - 1'b1;
          else if (trig) begin
            st <= S_CONV; cnt <= K_CONV; tmo <= '0;
            mode_q <= narrow; second <= 1'b0; seen_hi <= 1'b0;
          end
        end
        S_CONV: begin
          if (cnt == '0) st <= S_WAIT;
          else cnt <= cnt - 1'b1;
        end
        S_WAIT: begin
          if (adc_active) seen_hi <= 1'b1;
          if (seen_hi && !adc_active) begin
            st <= S_READ; cnt <= K_RD;
          end else if (tmo >= K_TMO) begin
            st <= S_IDLE; res_err <= 1'b1; hold <= K_HOLD;
          end
        end
        S_READ: begin
          if (cnt != '0) cnt <= cnt - 1'b1;
          else if (mode_q && !second) begin
            upper <= adc_data[HB-1:0]; second <= 1'b1;
            st <= S_GAP; cnt <= K_GAP;
          end else begin
            res_data  <= mode_q ? {upper, adc_data[HB-1:0]} : adc_data;
            res_valid <= 1'b1; second <= 1'b0;
            st <= S_IDLE; hold <= K_HOLD;
          end
        end
        S_GAP: begin
          if (cnt == '0) begin st <= S_READ; cnt <= K_RD; end
          else cnt <= cnt - 1'b1;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  logic [CNT_W-1:0] go_run, since_rd;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      go_run <= '0; since_rd <= '1;
    end else begin
      go_run   <= adc_go_n ? '0 : go_run + 1'b1;
      since_rd <= !adc_read_n ? '0 : (since_rd == '1 ? since_rd : since_rd + 1'b1);
    end
  end

  assert_go_width_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(adc_go_n) |-> go_run == CNT_W'(CONV_LO_CYC));
  assert_no_read_busy_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !adc_read_n |-> !adc_active);
  assert_read_sel_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !adc_read_n |-> !adc_sel_n);
  assert_half_edge_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(adc_half) |-> adc_read_n);
  assert_valid_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |=> !res_valid);
  assert_guard_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(adc_go_n) |-> since_rd >= K_HOLD);
  assert_err_release_R9: assert property (@(posedge clk) disable iff (!rst_n)
    res_err |-> (adc_sel_n && adc_read_n && !res_valid));
endmodule

// File: tb/adc_par_seq_tb.sv
module adc_par_seq_tb;
  localparam int CONV_LO = 2, RD_LO = 5, RD_HI = 2, HOLD = 15, TMO = 100;
  localparam int BUSY_DLY = 3, CONV_T = 55;

  logic clk = 1'b0, rst_n = 1'b0, trig = 1'b0, nar_cfg = 1'b0, busy = 1'b0;
  logic [15:0] adc_data, res_data, sample = '0, held = '0;
  logic go_n, sel_n, read_n, half, res_valid, res_err;
  int mode = 0;
  logic release_busy = 1'b0;

  always #4 clk = ~clk;

  adc_par_seq #(.CONV_LO_CYC(CONV_LO), .CONV_HI_CYC(2), .RD_LO_CYC(RD_LO), .RD_HI_CYC(RD_HI),
    .HALF_GAP_CYC(5), .GUARD_CYC(5), .ACQ_CYC(HOLD), .TIMEOUT_CYC(TMO)) u_dut (
    .clk(clk), .rst_n(rst_n), .trig(trig), .narrow(nar_cfg), .adc_active(busy),
    .adc_data(adc_data), .adc_go_n(go_n), .adc_sel_n(sel_n), .adc_read_n(read_n),
    .adc_half(half), .res_valid(res_valid), .res_data(res_data), .res_err(res_err));

  assign adc_data = read_n ? 16'hBEEF :
                    (nar_cfg ? {8'hC3, half ? held[7:0] : held[15:8]} : held);

  initial forever begin
    @(negedge go_n);
    if (mode == 0) begin
      repeat (BUSY_DLY) @(posedge clk); busy = 1'b1;
      repeat (CONV_T) @(posedge clk); held = sample; busy = 1'b0;
    end else if (mode == 2) begin
      repeat (BUSY_DLY) @(posedge clk); busy = 1'b1;
      wait (release_busy); @(posedge clk); busy = 1'b0;
    end
  end

  int checks = 0, errors = 0;
  task automatic chk(input logic ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  logic [15:0] exp_q[$];
  int n_valid = 0, n_err = 0, go_falls = 0, reads = 0;
  int go_low = 0, rd_low = 0, rd_high = 1000, since_go = 0;
  logic prev_go = 1'b1, prev_rd = 1'b1, busy_in_rd = 1'b0, half_bad = 1'b0, seen_busy = 1'b0;

  always @(negedge clk) if (rst_n) begin
    since_go++;
    if (!go_n && prev_go) begin
      go_falls++; reads = 0; since_go = 0; seen_busy = 1'b0;
      chk(rd_high >= HOLD, "R8 guard", rd_high, HOLD);
    end
    if (busy) seen_busy = 1'b1;
    if (!go_n) go_low++;
    else if (!prev_go) begin
      chk(go_low == CONV_LO && !sel_n, "R2 go width", go_low, CONV_LO);
      go_low = 0;
    end
    if (!read_n) begin
      if (prev_rd) begin
        chk(seen_busy, "R3 read after busy", seen_busy, 1);
        if (reads == 1) chk(rd_high >= RD_HI, "R6 read gap", rd_high, RD_HI);
        half_bad = (half != (reads == 1));
      end
      if (busy) busy_in_rd = 1'b1;
      if (sel_n) half_bad = 1'b1;
      rd_low++; rd_high = 0;
    end else begin
      if (!prev_rd) begin
        chk(rd_low == RD_LO, "R4 read width", rd_low, RD_LO);
        chk(!busy_in_rd, "R3 no read while busy", busy_in_rd, 0);
        chk(!half_bad, "R6 byte select/sel during read", half_bad, 0);
        reads++; rd_low = 0; busy_in_rd = 1'b0;
      end
      if (rd_high < 100000) rd_high++;
    end
    if (res_valid) begin
      logic [15:0] e;
      n_valid++;
      e = (exp_q.size() > 0) ? exp_q.pop_front() : 16'hXXXX;
      chk(res_data === e, nar_cfg ? "R6 narrow result" : "R5 wide result", res_data, e);
      chk(reads == (nar_cfg ? 2 : 1), "R5/R6 read count", reads, nar_cfg ? 2 : 1);
    end
    if (res_err) begin
      n_err++;
      chk(since_go == TMO, "R9 timeout cycle", since_go, TMO);
    end
    prev_go = go_n; prev_rd = read_n;
  end

  int convs = 0;
  task automatic run_conv(input logic [15:0] v, input logic nar, input logic poke);
    int nv;
    nv = n_valid;
    sample = v; nar_cfg = nar; exp_q.push_back(v); convs++;
    @(posedge clk); trig <= 1'b1;
    wait (!go_n); @(posedge clk); trig <= 1'b0;
    if (poke) begin
      repeat (10) @(posedge clk); trig <= 1'b1; @(posedge clk); trig <= 1'b0;
    end
    while (n_valid == nv) @(posedge clk);
  endtask

  task automatic run_timeout(input int m);
    int ne, nv;
    ne = n_err; nv = n_valid; mode = m; convs++;
    @(posedge clk); trig <= 1'b1;
    wait (!go_n); @(posedge clk); trig <= 1'b0;
    while (n_err == ne) @(posedge clk);
    @(negedge clk);
    chk(n_valid == nv, "R9 no valid on timeout", n_valid - nv, 0);
    chk(sel_n && read_n, "R9 bus released", {sel_n, read_n}, 2'b11);
    release_busy = 1'b1; repeat (3) @(posedge clk); release_busy = 1'b0;
    mode = 0;
  endtask

  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      errors++; checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(go_n && sel_n && read_n && !half && !res_valid && !res_err, "R1 reset state",
        {go_n, sel_n, read_n, half, res_valid, res_err}, 6'b111000);
    rst_n = 1'b1;
    run_conv(16'h7FFF, 1'b0, 1'b0);
    run_conv(16'h8000, 1'b0, 1'b0);
    run_conv(16'h0001, 1'b0, 1'b0);
    run_conv(16'hFFFF, 1'b0, 1'b0);
    run_conv(16'hA55A, 1'b1, 1'b0);
    run_conv(16'h00FF, 1'b1, 1'b0);
    run_conv(16'hFF00, 1'b1, 1'b0);
    run_conv(16'h8001, 1'b1, 1'b0);
    run_conv(16'h1234, 1'b0, 1'b1);
    run_conv(16'h4321, 1'b1, 1'b1);
    repeat (HOLD + 20) @(posedge clk);
    @(negedge clk);
    chk(go_falls == convs, "R10 trig ignored while busy", go_falls, convs);
    chk(res_valid == 1'b0, "R7 valid is a pulse", res_valid, 0);
    run_timeout(1);
    run_timeout(2);
    repeat (HOLD + 5) @(posedge clk);
    run_conv(16'h5A5A, 1'b0, 1'b0);
    repeat (5) @(posedge clk);
    @(negedge clk);
    chk(exp_q.size() == 0, "R7 all results delivered", exp_q.size(), 0);
    chk(n_err == 2, "R9 error count", n_err, 2);
    chk(go_falls == convs, "R10 conversion count", go_falls, convs);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule